// File: doc/BRIEF.md
# Clear-Only Capture/Compare Timer

This block is a free-running up-counter with four capture/compare channels. A power-of-two prescaler sets how often the counter advances. Software drives it with single-cycle strobes: run, halt, zero and per-channel capture. Software cannot load the counter with a value. The only write to it is the zero strobe. To keep a time base, software records the count it sees and works out offsets from that.

Each channel holds a compare register. Software can write it directly, or a capture strobe can fill it with the live count. A channel raises a sticky event flag on the prescaled tick where the counter steps onto the compare value. The flag stays set until software acknowledges it. Interrupt enables are changed only through set and clear masks. A single interrupt line combines the flags that are enabled.

Top module: `cc_timer`

## Requirements
- R1: After reset, the count, every compare register, every event flag, every enable bit, the prescale field and the run state are all zero, and `irq` is 0.
- R2: A `task_clear` strobe makes the count 0 on the next edge and also zeroes the prescale divider. If an increment falls in the same cycle, the clear takes priority. No port loads the count with any other value.
- R3: `task_start` enables counting and `task_stop` disables it; stop wins if both arrive together. While counting is halted the count holds. The sequence halt, zero, then run restarts counting from 0.
- R4: With prescale field P (written through `presc_we`/`presc_wdata`), the count advances once every 2^P clocks. After a run strobe, k clocks later the count reads floor(k / 2^P).
- R5: A one on bit i of `task_capture` copies the count as it was before that edge's increment into compare register i. Compare register i sits at bits [i*CW +: CW] of `cmp_q`. If a capture and a `cmp_we` write hit the same channel in the same cycle, the capture takes priority.
- R6: Event flag i (bit i of `evt_flag`) is set on the prescaled tick where the count becomes equal to compare register i. It is set only on that step, and not again while the two values stay equal.
- R7: An event flag stays set until a one is written to its bit of `evt_ack`. If a new event and an acknowledge land on the same edge, the event wins.
- R8: Ones in `inten_set` set enable bits and ones in `inten_clr` clear them. Zero bits leave enables unchanged. If a bit is set and cleared in the same cycle, the clear wins.
- R9: `irq` is 1 exactly when some channel has both its event flag and its enable bit set.
- R10: The count wraps from all ones to 0. A compare register holding 0 raises its event on that wrap, but not when a clear strobe sets the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| task_start | input | 1 | Strobe: begin counting |
| task_stop | input | 1 | Strobe: halt counting |
| task_clear | input | 1 | Strobe: zero the count and the prescale divider |
| task_capture | input | NCH | Per-channel strobe: copy the count into the compare register |
| presc_we | input | 1 | Write strobe for the prescale field |
| presc_wdata | input | PW | Prescale exponent P |
| cmp_we | input | NCH | Per-channel write strobe for compare registers |
| cmp_wdata | input | CW | Compare write data |
| evt_ack | input | NCH | Ones clear the matching event flags |
| inten_set | input | NCH | Ones set the matching interrupt enables |
| inten_clr | input | NCH | Ones clear the matching interrupt enables |
| count | output | CW | Live counter value |
| cmp_q | output | NCH*CW | All compare registers, channel i at [i*CW +: CW] |
| evt_flag | output | NCH | Sticky compare event flags |
| inten | output | NCH | Interrupt enable bits |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can fall on the same edge and need a defined priority. The first is a zero strobe or a capture strobe landing on an edge where the count is also incrementing. The bench runs with prescale 0 so that every clock is a tick, then issues the strobe mid-count. The zero case passes only if the count reads 0 rather than one more than its old value. The capture case passes only if the captured value equals the count sampled just before the edge, even though a direct compare write is issued to the same channel in that cycle. The second pair is an enable set and an enable clear on the same bit in one cycle. It is judged by reading `inten` and `irq` afterwards.

// File: rtl/cc_timer.sv
module cc_timer #(
  parameter int CW  = 32,
  parameter int NCH = 4,
  parameter int PW  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              task_start,
  input  logic              task_stop,
  input  logic              task_clear,
  input  logic [NCH-1:0]    task_capture,
  input  logic              presc_we,
  input  logic [PW-1:0]     presc_wdata,
  input  logic [NCH-1:0]    cmp_we,
  input  logic [CW-1:0]     cmp_wdata,
  input  logic [NCH-1:0]    evt_ack,
  input  logic [NCH-1:0]    inten_set,
  input  logic [NCH-1:0]    inten_clr,
  output logic [CW-1:0]     count,
  output logic [NCH*CW-1:0] cmp_q,
  output logic [NCH-1:0]    evt_flag,
  output logic [NCH-1:0]    inten,
  output logic              irq
);
  localparam int DW = (1 << PW) - 1;

  logic              running;
  logic [PW-1:0]     presc;
  logic [DW-1:0]     div_q;
  logic [DW-1:0]     div_mask;
  logic              tick;
  logic [CW-1:0]     cnt_inc;
  logic [NCH-1:0][CW-1:0] cmp_r;

  assign div_mask = (DW'(1) << presc) - DW'(1);
  assign tick     = running && ((div_q & div_mask) == div_mask);
  assign cnt_inc  = count + CW'(1);
  assign cmp_q    = cmp_r;
  assign irq      = |(evt_flag & inten);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      presc   <= '0;
      div_q   <= '0;
      count   <= '0;
    end else begin
      if (task_stop)       running <= 1'b0;
      else if (task_start) running <= 1'b1;
      if (presc_we) presc <= presc_wdata;
      if (task_clear)   div_q <= '0;
      else if (running) div_q <= div_q + DW'(1);
      if (task_clear) count <= '0;
      else if (tick)  count <= cnt_inc;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_r[i]    <= '0;
        evt_flag[i] <= 1'b0;
        inten[i]    <= 1'b0;
      end else begin
        if (task_capture[i]) cmp_r[i] <= count;
        else if (cmp_we[i])  cmp_r[i] <= cmp_wdata;
        if (tick && !task_clear && cnt_inc == cmp_r[i]) evt_flag[i] <= 1'b1;
        else if (evt_ack[i])                            evt_flag[i] <= 1'b0;
        if (inten_clr[i])      inten[i] <= 1'b0;
        else if (inten_set[i]) inten[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cc_timer_chk.sv
module cc_timer_chk #(
  parameter int CW  = 32,
  parameter int NCH = 4,
  parameter int PW  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              task_start,
  input logic              task_stop,
  input logic              task_clear,
  input logic [NCH-1:0]    task_capture,
  input logic [NCH-1:0]    evt_ack,
  input logic [NCH-1:0]    inten_set,
  input logic [NCH-1:0]    inten_clr,
  input logic [CW-1:0]     count,
  input logic [NCH*CW-1:0] cmp_q,
  input logic [NCH-1:0]    evt_flag,
  input logic [NCH-1:0]    inten
);
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    task_clear |=> count == '0);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !task_clear |=> (count == $past(count) || count == $past(count) + CW'(1)));

  p_halt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (task_stop && !task_start) ##1 (!task_start && !task_clear) |=> $stable(count));

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      task_capture[i] |=> cmp_q[i*CW +: CW] == $past(count));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      evt_flag[i] && !evt_ack[i] |=> evt_flag[i]);

    p_en_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inten_set[i] && !inten_clr[i] |=> inten[i]);

    p_en_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      inten_clr[i] |=> !inten[i]);
  end
endmodule

bind cc_timer cc_timer_chk #(.CW(CW), .NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
  .task_clear(task_clear), .task_capture(task_capture), .evt_ack(evt_ack),
  .inten_set(inten_set), .inten_clr(inten_clr), .count(count), .cmp_q(cmp_q),
  .evt_flag(evt_flag), .inten(inten)
);

// File: tb/test_cc_timer.sv
`timescale 1ns/1ps
module test_cc_timer;
  localparam int CW = 8, NCH = 4, PW = 4;

  logic clk = 0, rst_n = 0;
  logic task_start = 0, task_stop = 0, task_clear = 0, presc_we = 0;
  logic [NCH-1:0] task_capture = 0, cmp_we = 0, evt_ack = 0, inten_set = 0, inten_clr = 0;
  logic [PW-1:0] presc_wdata = 0;
  logic [CW-1:0] cmp_wdata = 0;
  logic [CW-1:0] count;
  logic [NCH*CW-1:0] cmp_q;
  logic [NCH-1:0] evt_flag, inten;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cc_timer #(.CW(CW), .NCH(NCH), .PW(PW)) i_cc_timer (
    .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_stop(task_stop),
    .task_clear(task_clear), .task_capture(task_capture), .presc_we(presc_we),
    .presc_wdata(presc_wdata), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .evt_ack(evt_ack), .inten_set(inten_set), .inten_clr(inten_clr),
    .count(count), .cmp_q(cmp_q), .evt_flag(evt_flag), .inten(inten), .irq(irq)
  );

  // {P, clocks after run strobe, expected count}
  localparam logic [23:0] VEC [5] = '{24'h00_0A_0A, 24'h01_0B_05, 24'h02_09_02,
                                      24'h03_11_02, 24'h04_28_02};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] cmp_of(input int ch);
    return cmp_q[ch*CW +: CW];
  endfunction

  task automatic restart(input logic [PW-1:0] p, input int k);
    @(negedge clk); task_stop = 1; task_clear = 1; presc_we = 1; presc_wdata = p;
    @(negedge clk); task_stop = 0; task_clear = 0; presc_we = 0; task_start = 1;
    @(negedge clk); task_start = 0;
    repeat (k) @(negedge clk);
  endtask

  task automatic halt_and_ack;
    @(negedge clk); task_stop = 1; evt_ack = '1;
    @(negedge clk); task_stop = 0; evt_ack = 0;
  endtask

  task automatic write_cmp(input int ch, input logic [CW-1:0] v);
    @(negedge clk); cmp_we[ch] = 1; cmp_wdata = v;
    @(negedge clk); cmp_we = 0;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [CW-1:0] c;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 count", count, 0);
    chk("R1 cmp", cmp_q, 0);
    chk("R1 evt", evt_flag, 0);
    chk("R1 inten", inten, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;

    // R3/R4 prescale table, each row halt-zero-run
    for (int v = 0; v < 5; v++) begin
      restart(VEC[v][19:16], int'(VEC[v][15:8]));
      chk("R4 prescale count", count, VEC[v][7:0]);
    end

    // R2 clear beats increment
    restart(0, 20);
    @(negedge clk); task_clear = 1;
    @(negedge clk); task_clear = 0;
    chk("R2 clear wins", count, 0);
    @(negedge clk);
    chk("R2 count after clear", count, 1);

    // R5 capture pre-increment value, beats direct write
    c = count;
    task_capture[1] = 1; cmp_we[1] = 1; cmp_wdata = 8'hAA;
    @(negedge clk); task_capture = 0; cmp_we = 0;
    chk("R5 captured value", cmp_of(1), c);
    chk("R5 count advanced", count, c + 1);

    // R3 halt holds count
    @(negedge clk); task_stop = 1;
    @(negedge clk); task_stop = 0;
    c = count;
    repeat (5) @(negedge clk);
    chk("R3 halted count", count, c);

    // R6 event on reaching compare
    halt_and_ack;
    write_cmp(0, 5);
    write_cmp(3, 8'h30);
    restart(0, 4);
    chk("R6 no early event", evt_flag[0], 0);
    @(negedge clk);
    chk("R6 event at match", evt_flag[0], 1);
    chk("R6 count at match", count, 5);
    repeat (3) @(negedge clk);
    chk("R7 flag sticky", evt_flag[0], 1);

    // R6 once-only while equal (P=3, compare 1)
    halt_and_ack;
    write_cmp(3, 1);
    restart(3, 8);
    chk("R6 slow event", evt_flag[3], 1);
    evt_ack[3] = 1;
    @(negedge clk); evt_ack = 0;
    chk("R7 ack clears", evt_flag[3], 0);
    repeat (4) @(negedge clk);
    chk("R6 still equal", count, 1);
    chk("R6 not refired", evt_flag[3], 0);

    // R8/R9 enables and interrupt
    halt_and_ack;
    inten_set = 4'b0001;
    @(negedge clk); inten_set = 4'b0100;
    @(negedge clk); inten_set = 0;
    chk("R8 set mask accumulates", inten, 4'b0101);
    chk("R9 no flag no irq", irq, 0);
    write_cmp(0, 1);
    restart(0, 1);
    chk("R9 irq on enabled flag", irq, 1);
    inten_clr = 4'b0001;
    @(negedge clk); inten_clr = 0;
    chk("R8 clear mask", inten, 4'b0100);
    chk("R9 irq drops", irq, 0);
    chk("R7 flag kept", evt_flag[0], 1);
    inten_set = 4'b0100; inten_clr = 4'b0100;
    @(negedge clk); inten_set = 0; inten_clr = 0;
    chk("R8 clear beats set", inten, 0);

    // R10 wrap with compare 0
    halt_and_ack;
    write_cmp(2, 0);
    restart(0, 0);
    chk("R10 no event on clear", evt_flag[2], 0);
    repeat (255) @(negedge clk);
    chk("R10 at top", count, 8'hFF);
    chk("R10 none before wrap", evt_flag[2], 0);
    @(negedge clk);
    chk("R10 wrapped", count, 0);
    chk("R10 event on wrap", evt_flag[2], 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule